// File: doc/BRIEF.md
# SHA-256 Compression Round Engine with Rescheduled Datapath

This block runs the SHA-256 compression function on one 512-bit block at a time. It does not pad the message and it does not expand the message schedule. The caller supplies one 32-bit schedule word per clock. The 64 round constants come from a small ROM inside the block, which is addressed ahead of the round that uses them.

Each round is split into two register stages. The first stage forms the sum of the word that becomes H in the next round (the current G), the round constant and the schedule word. The second stage computes only the new A and E; the other six working variables are shifted copies of earlier values. In the last round the chaining words for A and E are added into the A and E results. The other six chaining words are then folded in by two adders over three cycles, while the working registers shift past them.

The eight chaining (digest) words form a circular ring, and `digest_word` always shows the head word. Stepping the ring serves two purposes: it reads out the digest, or it shifts a custom initial value in through the last slot. A standard-value reload is also available. This lets hashing resume on fragmented messages or keyed constructions.

The controller has five states:
- IDLE: ring and reload commands are accepted here.
- LOAD: the working registers are copied from the ring and the first pre-sum is formed.
- ROUND: 64 cycles, one round per cycle.
- FOLD: three cycles that add the six shifted words into the ring.
- FINISH: a one-cycle completion state.

Transitions:
- IDLE→LOAD when `start` is seen.
- LOAD→ROUND unconditionally.
- ROUND→FOLD after round 63.
- FOLD→FINISH after the third fold step.
- FINISH→IDLE unconditionally.

Top module: `sha256_resched_core`

## Requirements
- R1: After reset the block is idle with `busy`=0 and `done`=0. The ring holds the standard initial value, so `digest_word` reads 32'h6a09e667.
- R2: When `iv_std` is high in IDLE and `start` is low, the ring reloads the eight standard initial words H0..H7 on the next edge. This takes priority over `ring_step`.
- R3: After the edge that samples `start` in IDLE, `busy` is high from the next cycle. The schedule word W[i] (i=0..63) is sampled on the (i+1)-th rising edge after that edge.
- R4: One block of the padded message "abc" started from the standard value yields the digest ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R5: A block started without a reload uses the ring contents as its chaining value. The two padded blocks of the 448-bit test message "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq" yield 248d6a61 d20638b8 e5c02693 0c3e6039 a33ce459 64ff2167 f6ecedd4 19db06c1.
- R6: `done` is high for exactly one cycle. That cycle follows the 68th rising edge after the edge that sampled `start`, and `busy` is low in it.
- R7: When `ring_step`=1 and `ring_in_sel`=0 in IDLE, with `start` and `iv_std` low, the ring rotates by one word toward the head. Eight steps present H0 first and H7 last, and leave the ring as it was.
- R8: When `ring_step`=1 and `ring_in_sel`=1 in IDLE, `ring_in` enters the last slot and the other words move toward the head. After eight steps the first word loaded is at the head, and a following block uses the loaded words as its chaining value.
- R9: `start`, `iv_std` and `ring_step` have no effect while `busy` is high. The digest of the running block is unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin compressing one block (accepted in IDLE) |
| w_word | input | 32 | Schedule word for the round being fed |
| iv_std | input | 1 | Reload the standard initial value into the ring |
| ring_step | input | 1 | Advance the digest ring by one word |
| ring_in_sel | input | 1 | 1: shift `ring_in` into the last slot; 0: rotate |
| ring_in | input | 32 | Word shifted in when loading a custom initial value |
| busy | output | 1 | Block compression in progress |
| done | output | 1 | One-cycle completion pulse |
| digest_word | output | 32 | Head word of the digest ring |

## Verification
The assertions assume the three IDLE commands are only meaningful in IDLE. The ring properties are guarded so that they apply only when `start` is low, because `start` takes precedence.

They also assume the caller keeps W[i] stable across the edge that samples it. The stimulus meets this by changing `w_word` on falling edges in a fixed order after `start`. The stimulus also raises every command together in the middle of a block, to show that they are ignored while busy.

// File: rtl/sha256r_pkg.sv
package sha256r_pkg;

    localparam int WW          = 32;
    localparam int ROUNDS      = 64;
    localparam int NWORDS      = 8;
    localparam int CW          = $clog2(ROUNDS);
    localparam int FOLD_STEPS  = (NWORDS - 2) / 2;
    localparam int HALF        = NWORDS / 2;

    typedef logic [WW-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ROUND,
        S_FOLD,
        S_FINISH
    } state_t;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WW - n));
    endfunction

    function automatic word_t std_iv(input int idx);
        case (idx)
            0:       return 32'h6a09e667;
            1:       return 32'hbb67ae85;
            2:       return 32'h3c6ef372;
            3:       return 32'ha54ff53a;
            4:       return 32'h510e527f;
            5:       return 32'h9b05688c;
            6:       return 32'h1f83d9ab;
            default: return 32'h5be0cd19;
        endcase
    endfunction

endpackage

// File: rtl/sha256r_krom.sv
module sha256r_krom
    import sha256r_pkg::*;
(
    input  logic          clk,
    input  logic [CW-1:0] addr,
    output word_t         k_q
);

    function automatic word_t kval(input logic [5:0] i);
        case (i)
            6'd0:  return 32'h428a2f98;  6'd1:  return 32'h71374491;
            6'd2:  return 32'hb5c0fbcf;  6'd3:  return 32'he9b5dba5;
            6'd4:  return 32'h3956c25b;  6'd5:  return 32'h59f111f1;
            6'd6:  return 32'h923f82a4;  6'd7:  return 32'hab1c5ed5;
            6'd8:  return 32'hd807aa98;  6'd9:  return 32'h12835b01;
            6'd10: return 32'h243185be;  6'd11: return 32'h550c7dc3;
            6'd12: return 32'h72be5d74;  6'd13: return 32'h80deb1fe;
            6'd14: return 32'h9bdc06a7;  6'd15: return 32'hc19bf174;
            6'd16: return 32'he49b69c1;  6'd17: return 32'hefbe4786;
            6'd18: return 32'h0fc19dc6;  6'd19: return 32'h240ca1cc;
            6'd20: return 32'h2de92c6f;  6'd21: return 32'h4a7484aa;
            6'd22: return 32'h5cb0a9dc;  6'd23: return 32'h76f988da;
            6'd24: return 32'h983e5152;  6'd25: return 32'ha831c66d;
            6'd26: return 32'hb00327c8;  6'd27: return 32'hbf597fc7;
            6'd28: return 32'hc6e00bf3;  6'd29: return 32'hd5a79147;
            6'd30: return 32'h06ca6351;  6'd31: return 32'h14292967;
            6'd32: return 32'h27b70a85;  6'd33: return 32'h2e1b2138;
            6'd34: return 32'h4d2c6dfc;  6'd35: return 32'h53380d13;
            6'd36: return 32'h650a7354;  6'd37: return 32'h766a0abb;
            6'd38: return 32'h81c2c92e;  6'd39: return 32'h92722c85;
            6'd40: return 32'ha2bfe8a1;  6'd41: return 32'ha81a664b;
            6'd42: return 32'hc24b8b70;  6'd43: return 32'hc76c51a3;
            6'd44: return 32'hd192e819;  6'd45: return 32'hd6990624;
            6'd46: return 32'hf40e3585;  6'd47: return 32'h106aa070;
            6'd48: return 32'h19a4c116;  6'd49: return 32'h1e376c08;
            6'd50: return 32'h2748774c;  6'd51: return 32'h34b0bcb5;
            6'd52: return 32'h391c0cb3;  6'd53: return 32'h4ed8aa4a;
            6'd54: return 32'h5b9cca4f;  6'd55: return 32'h682e6ff3;
            6'd56: return 32'h748f82ee;  6'd57: return 32'h78a5636f;
            6'd58: return 32'h84c87814;  6'd59: return 32'h8cc70208;
            6'd60: return 32'h90befffa;  6'd61: return 32'ha4506ceb;
            6'd62: return 32'hbef9a3f7;  default: return 32'hc67178f2;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        k_q <= kval(6'(addr));
    end

endmodule

// File: rtl/sha256r_step.sv
module sha256r_step
    import sha256r_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  word_t c,
    input  word_t d,
    input  word_t e,
    input  word_t f,
    input  word_t g,
    input  word_t hkw,
    input  word_t add_a,
    input  word_t add_e,
    output word_t a_nx,
    output word_t e_nx
);

    word_t big_s0, big_s1, ch, maj, t1, t2;

    always_comb begin
        big_s1 = rotr(e, 6) ^ rotr(e, 11) ^ rotr(e, 25);
        ch     = (e & f) ^ (~e & g);
        big_s0 = rotr(a, 2) ^ rotr(a, 13) ^ rotr(a, 22);
        maj    = (a & b) ^ (a & c) ^ (b & c);
        t1     = hkw + big_s1 + ch;
        t2     = big_s0 + maj;
        a_nx   = t1 + t2 + add_a;
        e_nx   = d + t1 + add_e;
    end

endmodule

// File: rtl/sha256_resched_core.sv
module sha256_resched_core
    import sha256r_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] w_word,
    input  logic        iv_std,
    input  logic        ring_step,
    input  logic        ring_in_sel,
    input  logic [31:0] ring_in,
    output logic        busy,
    output logic        done,
    output logic [31:0] digest_word
);

    state_t        st, st_nx;
    logic [CW-1:0] cnt;
    word_t         ra, rb, rc, rd, re, rf, rg, rh;
    word_t         hkw;
    word_t         dg [NWORDS];
    word_t         k_q;
    logic [CW-1:0] k_addr;
    word_t         a_nx, e_nx;
    logic          last_rnd;
    logic [2:0]    lo_idx, hi_idx;

    assign last_rnd    = (st == S_ROUND) && (cnt == CW'(ROUNDS - 1));
    assign lo_idx      = 3'(FOLD_STEPS - int'(cnt[1:0]));
    assign hi_idx      = 3'(int'(lo_idx) + HALF);
    assign digest_word = dg[0];

    always_comb begin
        unique case (st)
            S_LOAD:  k_addr = CW'(1);
            S_ROUND: k_addr = CW'(cnt + CW'(2));
            default: k_addr = '0;
        endcase
    end

    sha256r_krom u_krom (
        .clk  (clk),
        .addr (k_addr),
        .k_q  (k_q)
    );

    sha256r_step u_step (
        .a     (ra),
        .b     (rb),
        .c     (rc),
        .d     (rd),
        .e     (re),
        .f     (rf),
        .g     (rg),
        .hkw   (hkw),
        .add_a (last_rnd ? dg[0] : '0),
        .add_e (last_rnd ? dg[HALF] : '0),
        .a_nx  (a_nx),
        .e_nx  (e_nx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (start) st_nx = S_LOAD;
            S_LOAD:   st_nx = S_ROUND;
            S_ROUND:  if (cnt == CW'(ROUNDS - 1)) st_nx = S_FOLD;
            S_FOLD:   if (cnt == CW'(FOLD_STEPS - 1)) st_nx = S_FINISH;
            S_FINISH: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (st)
            S_LOAD, S_ROUND, S_FOLD: busy = 1'b1;
            S_FINISH:                done = 1'b1;
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {ra, rb, rc, rd, re, rf, rg, rh} <= '0;
            hkw <= '0;
            cnt <= '0;
            for (int i = 0; i < NWORDS; i++) dg[i] <= std_iv(i);
        end else begin
            unique case (st)
                S_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        cnt <= '0;
                    end else if (iv_std) begin
                        for (int i = 0; i < NWORDS; i++) dg[i] <= std_iv(i);
                    end else if (ring_step) begin
                        for (int i = 0; i < NWORDS - 1; i++) dg[i] <= dg[i+1];
                        dg[NWORDS-1] <= ring_in_sel ? ring_in : dg[0];
                    end
                end
                S_LOAD: begin
                    ra <= dg[0]; rb <= dg[1]; rc <= dg[2]; rd <= dg[3];
                    re <= dg[4]; rf <= dg[5]; rg <= dg[6]; rh <= dg[7];
                    hkw <= dg[NWORDS-1] + k_q + w_word;
                    cnt <= '0;
                end
                S_ROUND: begin
                    ra <= a_nx; rb <= ra; rc <= rb; rd <= rc;
                    re <= e_nx; rf <= re; rg <= rf; rh <= rg;
                    hkw <= rg + k_q + w_word;
                    if (last_rnd) begin
                        dg[0]    <= a_nx;
                        dg[HALF] <= e_nx;
                        cnt      <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                S_FOLD: begin
                    dg[lo_idx] <= dg[lo_idx] + rd;
                    dg[hi_idx] <= dg[hi_idx] + rh;
                    rd <= rc; rc <= rb;
                    rh <= rg; rg <= rf;
                    cnt <= cnt + CW'(1);
                end
                S_FINISH: cnt <= '0;
                default:  cnt <= '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start) |=> busy);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_after_fold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_FOLD && cnt == CW'(FOLD_STEPS - 1)) |=> (done && !busy));

    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE && start) |=> (st != S_LOAD));

    a_r9_ring_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ROUND && cnt != CW'(ROUNDS - 1)) |=> $stable(digest_word));

    a_r2_std_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start && iv_std) |=> (digest_word == 32'h6a09e667));

    a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start && !iv_std && ring_step && !ring_in_sel)
        |=> (digest_word == $past(dg[1])));

    a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start && !iv_std && ring_step && ring_in_sel)
        |=> (dg[NWORDS-1] == $past(ring_in)));

endmodule

// File: tb/sim_sha256_resched_core.sv
`timescale 1ns/1ps
module sim_sha256_resched_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] w_word = '0;
    logic        iv_std = 1'b0;
    logic        ring_step = 1'b0;
    logic        ring_in_sel = 1'b0;
    logic [31:0] ring_in = '0;
    logic        busy, done;
    logic [31:0] digest_word;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] blk [16];
    logic [31:0] sch [64];
    logic [31:0] exp8 [8];

    always #2 clk = ~clk;

    sha256_resched_core u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .w_word(w_word),
        .iv_std(iv_std), .ring_step(ring_step), .ring_in_sel(ring_in_sel),
        .ring_in(ring_in), .busy(busy), .done(done), .digest_word(digest_word)
    );

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic build_schedule();
        for (int t = 0; t < 64; t++) begin
            if (t < 16) sch[t] = blk[t];
            else sch[t] = (rr(sch[t-2], 17) ^ rr(sch[t-2], 19) ^ (sch[t-2] >> 10))
                        + sch[t-7]
                        + (rr(sch[t-15], 7) ^ rr(sch[t-15], 18) ^ (sch[t-15] >> 3))
                        + sch[t-16];
        end
    endtask

    // R3 R6 R9: feed one block, check busy and done timing
    task automatic run_block(input logic disturb);
        build_schedule();
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            start     = (disturb && i == 20);
            iv_std    = (disturb && i == 20);
            ring_step = (disturb && i == 20);
            w_word    = sch[i];
            if (i == 0) check("R3 busy", {31'b0, busy}, 32'd1);
        end
        @(negedge clk);
        w_word = '0;
        repeat (3) @(negedge clk);
        check("R6 done early", {31'b0, done}, 32'd0);
        @(negedge clk);
        check("R6 done", {31'b0, done}, 32'd1);
        check("R6 busy low", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check("R6 done one cycle", {31'b0, done}, 32'd0);
    endtask

    // R7: read all eight words through the ring
    task automatic read_digest(input string req);
        for (int i = 0; i < 8; i++) begin
            check(req, digest_word, exp8[i]);
            ring_step = 1'b1; ring_in_sel = 1'b0;
            @(negedge clk);
        end
        ring_step = 1'b0;
        check("R7 ring restored", digest_word, exp8[0]);
    endtask

    task automatic set_std_iv_exp();
        exp8 = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    endtask

    task automatic set_abc_block();
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[0]  = 32'h61626380;
        blk[15] = 32'h00000018;
    endtask

    task automatic set_abc_exp();
        exp8 = '{32'hba7816bf, 32'h8f01cfea, 32'h414140de, 32'h5dae2223,
                 32'hb00361a3, 32'h96177a9c, 32'hb410ff61, 32'hf20015ad};
    endtask

    task automatic t_reset();
        check("R1 busy", {31'b0, busy}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        check("R1 head", digest_word, 32'h6a09e667);
        set_std_iv_exp();
        read_digest("R1 iv word");
    endtask

    task automatic t_abc();
        @(negedge clk); iv_std = 1'b1;
        @(negedge clk); iv_std = 1'b0;
        set_abc_block();
        run_block(1'b0);
        set_abc_exp();
        read_digest("R4 abc digest");
    endtask

    task automatic t_two_block();
        @(negedge clk); iv_std = 1'b1;
        @(negedge clk); iv_std = 1'b0;
        blk = '{32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
        run_block(1'b0);
        for (int i = 0; i < 16; i++) blk[i] = '0;
        blk[15] = 32'h000001c0;
        run_block(1'b1);   // R9: commands pulsed mid-block
        exp8 = '{32'h248d6a61, 32'hd20638b8, 32'he5c02693, 32'h0c3e6039,
                 32'ha33ce459, 32'h64ff2167, 32'hf6ecedd4, 32'h19db06c1};
        read_digest("R5 R9 two-block digest");
    endtask

    task automatic load_ring();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ring_step = 1'b1; ring_in_sel = 1'b1; ring_in = exp8[i];
        end
        @(negedge clk);
        ring_step = 1'b0; ring_in_sel = 1'b0;
    endtask

    task automatic t_custom_iv();
        for (int i = 0; i < 8; i++) exp8[i] = 32'h11111111 * (i + 1);
        load_ring();
        check("R8 head after load", digest_word, 32'h11111111);
        read_digest("R8 loaded order");
        set_std_iv_exp();
        load_ring();
        set_abc_block();
        run_block(1'b0);
        set_abc_exp();
        read_digest("R8 custom iv digest");
    endtask

    task automatic t_iv_std();
        for (int i = 0; i < 8; i++) exp8[i] = 32'hdead0000 + i;
        load_ring();
        @(negedge clk); iv_std = 1'b1; ring_step = 1'b1; ring_in_sel = 1'b1;
        @(negedge clk); iv_std = 1'b0; ring_step = 1'b0; ring_in_sel = 1'b0;
        set_std_iv_exp();
        read_digest("R2 std reload");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_abc();
        t_two_block();
        t_custom_iv();
        t_iv_std();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule